// File: doc/BRIEF.md
# Parallel Pin Sequencer for Serial-Port Lines

This block lets a group of eight serial-port pins work in one of two ways. In serial mode the pins simply carry whatever the UART drives. In parallel mode they become a general-purpose 8-bit I/O port. Bytes from a stream input are placed on the pins as whole words, one after another and in arrival order. Each word is held for one prescaler period.

Pacing comes from the baud prescaler tick. A byte can only be taken on a tick, so the prescaler setting decides how fast the port steps through the stream. A per-pin direction mask picks which lines are driven. On each tick the block also captures a snapshot of the port, which is useful for reading switches or similar inputs.

The mode select is registered. After reset the block is in serial mode. Each time parallel mode is entered, its output enables stay off until the first byte arrives.

Top module: `bitbang_port`

## Requirements
- R1: In serial mode, `pin_out_o` equals `uart_out_i` and `pin_oe_o` equals `uart_oe_i`, and both follow those inputs in the same cycle.
- R2: A change on `par_mode_i` (1 = parallel, 0 = serial) reaches the pins at the first rising clock edge after the change. Before that edge the pins still show the previous mode.
- R3: `s_ready_o` is 1 only while the registered mode is parallel and `tick_i` is 1. A byte is accepted at a rising edge where both `s_ready_o` and `s_valid_i` are 1.
- R4: An accepted byte appears on `pin_out_o` right after the accepting edge. Bit i of the byte drives pin i. The byte stays on the pins until another byte is accepted.
- R5: A tick with `s_valid_i` low leaves `pin_out_o` unchanged.
- R6: Successive accepted bytes appear on the pins in the order they were offered.
- R7: In parallel mode, once armed, `pin_oe_o[i]` equals `dir_mask_i[i]` (1 = output, 0 = input), and it follows the mask in the same cycle.
- R8: Reset selects serial mode, clears the held byte and the snapshot to 0x00, and disarms the port. Whenever parallel mode is entered, `pin_oe_o` is 0x00 until the first byte is accepted.
- R9: At a rising edge with a tick in parallel mode, the snapshot is updated and `sample_o` shows it after that edge. Input pins (mask bit 0) take `pin_in_i[i]`; output pins take the bit driven before that edge. At all other edges, including every edge in serial mode, the snapshot is held.
- R10: In serial mode the stream is ignored. `s_ready_o` stays 0, and on return to parallel mode the pins show the byte held before serial mode was entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| par_mode_i | input | 1 | 1 = parallel port, 0 = serial |
| dir_mask_i | input | 8 | Per-pin direction, 1 = output |
| tick_i | input | 1 | Baud prescaler tick, one cycle wide |
| s_valid_i | input | 1 | Stream byte offered |
| s_data_i | input | 8 | Stream byte |
| s_ready_o | output | 1 | Byte taken this cycle when valid |
| uart_out_i | input | 8 | Pin values driven by the UART |
| uart_oe_i | input | 8 | Pin enables driven by the UART |
| pin_in_i | input | 8 | Values read back from the pads |
| pin_out_o | output | 8 | Pad output values |
| pin_oe_o | output | 8 | Pad output enables |
| sample_o | output | 8 | Port snapshot taken at the last tick |

## Verification
The outputs fall into two timing classes. `s_ready_o`, the serial pass-through and the direction-driven enables are combinational, so the bench checks them 1 ns after it drives the inputs, before the next edge. The held byte, the snapshot, the armed state and the mode register change one edge after the stimulus that causes them. The bench checks those 1 ns after that rising edge, so the registered effect is seen and the following stimulus has not yet been applied. For the mode switch, the bench checks both sides of the edge: the old mode is still on the pins just before it, and the new mode is there just after it.

// File: rtl/bb_pkg.sv
`timescale 1ns/1ps
package bb_pkg;
    typedef enum logic {
        MODE_SERIAL = 1'b0,
        MODE_PAR    = 1'b1
    } pin_mode_e;
endpackage

// File: rtl/bb_out_stage.sv
`timescale 1ns/1ps
module bb_out_stage
    import bb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_mode_i,
    input  logic         tick_i,
    input  logic         s_valid_i,
    input  logic [W-1:0] s_data_i,
    output logic         s_ready_o,
    output pin_mode_e    mode_o,
    output logic         armed_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        pin_mode_e    mode;
        logic         armed;
        logic [W-1:0] data;
    } st_t;

    st_t  st_d, st_q;
    logic take;

    always_comb begin
        st_d      = st_q;
        s_ready_o = (st_q.mode == MODE_PAR) && tick_i;
        take      = s_ready_o && s_valid_i;
        st_d.mode = par_mode_i ? MODE_PAR : MODE_SERIAL;
        if (take) begin
            st_d.data  = s_data_i;
            st_d.armed = 1'b1;
        end
        if (st_q.mode == MODE_SERIAL) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_SERIAL, armed: 1'b0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o  = st_q.mode;
    assign armed_o = st_q.armed;
    assign data_o  = st_q.data;

    // R3: the held byte only moves after an accepted handshake
    a_r3_change_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.data != $past(st_q.data)) |->
            $past(st_q.mode == MODE_PAR && tick_i && s_valid_i));

    // R5: a tick with no byte keeps the pins
    a_r5_hold_without_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !s_valid_i) |=> $stable(st_q.data));

    // R10: serial mode freezes the parallel data path
    a_r10_serial_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_SERIAL) |=> $stable(st_q.data));

    // R8: entering parallel mode starts disarmed
    a_r8_disarmed_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.mode == MODE_PAR) |-> !st_q.armed);
endmodule

// File: rtl/bb_in_sampler.sv
`timescale 1ns/1ps
module bb_in_sampler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] drv_i,
    input  logic [W-1:0] pin_in_i,
    output logic [W-1:0] sample_o
);
    logic [W-1:0] pick;
    logic [W-1:0] samp_d, samp_q;

    for (genvar i = 0; i < W; i++) begin : g_pick
        assign pick[i] = dir_i[i] ? drv_i[i] : pin_in_i[i];
    end

    always_comb begin
        samp_d = samp_q;
        if (en_i) begin
            samp_d = pick;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q <= '0;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign sample_o = samp_q;

    // R9: snapshot is held between ticks
    a_r9_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(samp_q));
endmodule

// File: rtl/bb_pin_mux.sv
`timescale 1ns/1ps
module bb_pin_mux
    import bb_pkg::*;
#(
    parameter int W = 8
) (
    input  pin_mode_e    mode_i,
    input  logic         armed_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] data_i,
    input  logic [W-1:0] uart_out_i,
    input  logic [W-1:0] uart_oe_i,
    output logic [W-1:0] pin_out_o,
    output logic [W-1:0] pin_oe_o
);
    logic par;
    assign par = (mode_i == MODE_PAR);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign pin_out_o[i] = par ? data_i[i] : uart_out_i[i];
        assign pin_oe_o[i]  = par ? (armed_i & dir_i[i]) : uart_oe_i[i];
    end
endmodule

// File: rtl/bitbang_port.sv
`timescale 1ns/1ps
module bitbang_port
    import bb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         par_mode_i,
    input  logic [W-1:0] dir_mask_i,
    input  logic         tick_i,
    input  logic         s_valid_i,
    input  logic [W-1:0] s_data_i,
    output logic         s_ready_o,
    input  logic [W-1:0] uart_out_i,
    input  logic [W-1:0] uart_oe_i,
    input  logic [W-1:0] pin_in_i,
    output logic [W-1:0] pin_out_o,
    output logic [W-1:0] pin_oe_o,
    output logic [W-1:0] sample_o
);
    pin_mode_e    mode_q;
    logic         armed_q;
    logic [W-1:0] data_q;
    logic         samp_en;

    bb_out_stage #(.W(W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_mode_i (par_mode_i),
        .tick_i     (tick_i),
        .s_valid_i  (s_valid_i),
        .s_data_i   (s_data_i),
        .s_ready_o  (s_ready_o),
        .mode_o     (mode_q),
        .armed_o    (armed_q),
        .data_o     (data_q)
    );

    assign samp_en = (mode_q == MODE_PAR) && tick_i;

    bb_in_sampler #(.W(W)) u_samp (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (samp_en),
        .dir_i    (dir_mask_i),
        .drv_i    (data_q),
        .pin_in_i (pin_in_i),
        .sample_o (sample_o)
    );

    bb_pin_mux #(.W(W)) u_mux (
        .mode_i     (mode_q),
        .armed_i    (armed_q),
        .dir_i      (dir_mask_i),
        .data_i     (data_q),
        .uart_out_i (uart_out_i),
        .uart_oe_i  (uart_oe_i),
        .pin_out_o  (pin_out_o),
        .pin_oe_o   (pin_oe_o)
    );

    // R1: serial mode hands the pins to the UART
    a_r1_serial_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_SERIAL) |-> (pin_out_o == uart_out_i && pin_oe_o == uart_oe_i));

    // R7: parallel mode never drives a pin marked as input
    a_r7_oe_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PAR) |-> ((pin_oe_o & ~dir_mask_i) == '0));
endmodule

// File: tb/bitbang_port_tb.sv
`timescale 1ns/1ps
module bitbang_port_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       par_mode_i;
    logic [7:0] dir_mask_i;
    logic       tick_i;
    logic       s_valid_i;
    logic [7:0] s_data_i;
    logic       s_ready_o;
    logic [7:0] uart_out_i;
    logic [7:0] uart_oe_i;
    logic [7:0] pin_in_i;
    logic [7:0] pin_out_o;
    logic [7:0] pin_oe_o;
    logic [7:0] sample_o;

    always #2.5 clk = ~clk;

    bitbang_port #(.W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .par_mode_i(par_mode_i), .dir_mask_i(dir_mask_i),
        .tick_i(tick_i), .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_ready_o(s_ready_o),
        .uart_out_i(uart_out_i), .uart_oe_i(uart_oe_i), .pin_in_i(pin_in_i),
        .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .sample_o(sample_o)
    );

    typedef struct packed {
        logic       t;
        logic       v;
        logic [7:0] d;
        logic [7:0] dir;
        logic [7:0] pin;
        logic [7:0] out;
        logic [7:0] oe;
        logic [7:0] samp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 8'hA5, 8'hF0, 8'h3C, 8'hA5, 8'hF0, 8'h0C},
        '{1'b0, 1'b1, 8'h11, 8'hF0, 8'hFF, 8'hA5, 8'hF0, 8'h0C},
        '{1'b1, 1'b0, 8'h22, 8'h0F, 8'h55, 8'hA5, 8'h0F, 8'h55},
        '{1'b1, 1'b1, 8'h3C, 8'hFF, 8'h00, 8'h3C, 8'hFF, 8'hA5},
        '{1'b1, 1'b1, 8'hC3, 8'h00, 8'h9A, 8'hC3, 8'h00, 8'h9A},
        '{1'b0, 1'b0, 8'h00, 8'hAA, 8'h00, 8'hC3, 8'hAA, 8'h9A},
        '{1'b1, 1'b1, 8'h7E, 8'hAA, 8'h0F, 8'h7E, 8'hAA, 8'h87}
    };

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic edge_settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; par_mode_i = 1'b0; dir_mask_i = 8'h00; tick_i = 1'b0;
        s_valid_i = 1'b0; s_data_i = 8'h00; uart_out_i = 8'h5A; uart_oe_i = 8'hC3;
        pin_in_i = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        tick_i = 1'b1;
        #1;
        // R8: reset state is serial mode, empty snapshot, no ready
        chk("R8 reset pin_out", pin_out_o, 8'h5A);
        chk("R8 reset pin_oe", pin_oe_o, 8'hC3);
        chk("R8 reset sample", sample_o, 8'h00);
        chk("R8 reset ready", {7'b0, s_ready_o}, 8'h00);
        rst_n = 1'b1;
        edge_settle();
        tick_i = 1'b0;
        par_mode_i = 1'b1;
        #1;
        chk("R2 old mode before edge", pin_out_o, 8'h5A);
        edge_settle();
        chk("R2 parallel after edge", pin_out_o, 8'h00);
        chk("R8 disarmed on entry", pin_oe_o, 8'h00);

        for (int k = 0; k < NV; k++) begin
            tick_i = VECS[k].t; s_valid_i = VECS[k].v; s_data_i = VECS[k].d;
            dir_mask_i = VECS[k].dir; pin_in_i = VECS[k].pin;
            #1;
            chk("R3 ready", {7'b0, s_ready_o}, {7'b0, VECS[k].t});
            edge_settle();
            chk("R4/R5/R6 pin_out", pin_out_o, VECS[k].out);
            chk("R7 pin_oe", pin_oe_o, VECS[k].oe);
            chk("R9 sample", sample_o, VECS[k].samp);
        end

        tick_i = 1'b0; s_valid_i = 1'b0; par_mode_i = 1'b0;
        #1;
        chk("R2 parallel held before edge", pin_out_o, 8'h7E);
        edge_settle();
        chk("R1 serial pin_out", pin_out_o, 8'h5A);
        chk("R1 serial pin_oe", pin_oe_o, 8'hC3);
        uart_out_i = 8'h96; uart_oe_i = 8'h3F;
        #1;
        chk("R1 serial follows out", pin_out_o, 8'h96);
        chk("R1 serial follows oe", pin_oe_o, 8'h3F);

        tick_i = 1'b1; s_valid_i = 1'b1; s_data_i = 8'h99; pin_in_i = 8'hFF;
        #1;
        chk("R10 no ready in serial", {7'b0, s_ready_o}, 8'h00);
        repeat (3) edge_settle();
        chk("R9 sample held in serial", sample_o, 8'h87);

        tick_i = 1'b0; s_valid_i = 1'b0; par_mode_i = 1'b1;
        edge_settle();
        chk("R10 old byte kept", pin_out_o, 8'h7E);
        chk("R8 disarmed on re-entry", pin_oe_o, 8'h00);

        dir_mask_i = 8'hFF; tick_i = 1'b1; s_valid_i = 1'b1; s_data_i = 8'hB4;
        edge_settle();
        tick_i = 1'b0; s_valid_i = 1'b0;
        chk("R4 byte after re-entry", pin_out_o, 8'hB4);
        chk("R8 armed after first byte", pin_oe_o, 8'hFF);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule